// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the address of a memory operand. It combines a base register value, an index register value, a two-bit scale code and a signed displacement. A three-bit mode select chooses how they combine. One shared datapath covers six memory addressing forms: a constant from the instruction, one register, two registers summed, a register plus a constant, two registers plus a constant, and a register plus an index multiplied by an element size.

When the real-mode enable is high, the computed effective address is used as an offset within a segment. The unit shifts the segment value left by four bits and adds the low 16 bits of the effective address. It truncates the sum to a 20-bit physical address inside the first megabyte.

A parameter chooses between two forms of output. The registered form, which is the default, captures a result on each input strobe. A two-state output controller, with states `ST_EMPTY` and `ST_LOADED`, then presents the result one clock later with a valid flag. The transition `T_CAPTURE` (in_valid high) enters or stays in `ST_LOADED`. The transition `T_DRAIN` (in_valid low) returns to `ST_EMPTY`. The combinational form passes the address straight through, and its valid flag follows the strobe.

Top module: `eag_unit`

## Requirements
- R1: Mode code 3'd0 (direct) yields the displacement sign-extended from 16 to 32 bits.
- R2: Mode code 3'd1 (register indirect) yields the base value unchanged.
- R3: Mode code 3'd2 (base plus index) yields base + index, modulo 2^32.
- R4: Mode code 3'd3 (register relative) yields base + sign-extended displacement, modulo 2^32. For example, base 0x300 with displacement 0x400 gives 0x700.
- R5: Mode code 3'd4 (base relative plus index) yields base + index + sign-extended displacement, modulo 2^32. For example, 0x300 + 0x200 + 0x400 gives 0x900.
- R6: Mode code 3'd5 (scaled index) yields base + index*M + sign-extended displacement, modulo 2^32. The scale code selects M: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. Other modes ignore the scale code.
- R7: Mode codes 3'd6 and 3'd7 are reserved and yield an address of zero.
- R8: With real_en high, the output is ((seg << 4) + EA[15:0]) mod 2^20, zero-extended to 32 bits. EA is the effective address of the selected mode, so bits 31..20 of the output are zero.
- R9: In the registered form, a strobe on in_valid at a clock edge makes addr show that strobe's address, and makes addr_valid high, after that edge.
- R10: In the registered form, an edge with in_valid low drops addr_valid to 0 and keeps addr at its previous value, whatever the other inputs do.
- R11: During and right after reset, addr is 0 and addr_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; operands are captured when high |
| mode | input | 3 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Element size code for the scaled index |
| disp | input | 16 | Signed displacement |
| seg_val | input | 16 | Segment value for real mode |
| real_en | input | 1 | Selects the 20-bit segment-plus-offset output |
| addr | output | 32 | Effective or physical address |
| addr_valid | output | 1 | Address valid flag |

## Verification
A wrong mode decode or shift amount shows as a wrong addr value one clock after the strobe that used it. The sweep covers every mode, scale code and real-mode setting, so each faulty term appears in the first vector that enables it. A stuck controller state shows as addr_valid out of step with in_valid on the very next edge. A missing hold shows as addr changing after an idle edge, and the bench compares addr with the value captured one edge earlier.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REG_IND  = 3'd1,
        AM_BASE_IDX = 3'd2,
        AM_REG_REL  = 3'd3,
        AM_BREL_IDX = 3'd4,
        AM_SCALED   = 3'd5,
        AM_RSV6     = 3'd6,
        AM_RSV7     = 3'd7
    } addr_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;

    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_disp;
        logic use_scale;
    } term_sel_t;

endpackage

// File: rtl/eag_scale.sv
module eag_scale #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] index_in,
    input  logic [SW-1:0] code,
    input  logic          enable,
    output logic [AW-1:0] scaled
);
    localparam int NSTEP = 1 << SW;

    logic [AW-1:0] steps [NSTEP];

    generate
        for (genvar g = 0; g < NSTEP; g++) begin : g_step
            assign steps[g] = index_in << g;
        end
    endgenerate

    always_comb begin
        scaled = enable ? steps[code] : index_in;
    end

    always_comb begin
        if (enable && code == '0) begin
            assert (scaled == index_in); // R6
        end
    end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
    import eag_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] index_in,
    input  logic [SW-1:0] scale_code,
    input  logic [DW-1:0] disp_in,
    output logic [AW-1:0] ea
);
    localparam int EXT = AW - DW;

    term_sel_t     sel;
    logic [AW-1:0] disp_x;
    logic [AW-1:0] idx_s;
    logic [AW-1:0] t_base, t_idx, t_disp;

    always_comb begin
        sel = '0;
        unique case (addr_mode_e'(mode))
            AM_DIRECT:   sel = '{use_base:1'b0, use_index:1'b0, use_disp:1'b1, use_scale:1'b0};
            AM_REG_IND:  sel = '{use_base:1'b1, use_index:1'b0, use_disp:1'b0, use_scale:1'b0};
            AM_BASE_IDX: sel = '{use_base:1'b1, use_index:1'b1, use_disp:1'b0, use_scale:1'b0};
            AM_REG_REL:  sel = '{use_base:1'b1, use_index:1'b0, use_disp:1'b1, use_scale:1'b0};
            AM_BREL_IDX: sel = '{use_base:1'b1, use_index:1'b1, use_disp:1'b1, use_scale:1'b0};
            AM_SCALED:   sel = '{use_base:1'b1, use_index:1'b1, use_disp:1'b1, use_scale:1'b1};
            AM_RSV6,
            AM_RSV7:     sel = '0;
        endcase
    end

    assign disp_x = {{EXT{disp_in[DW-1]}}, disp_in};

    eag_scale #(.AW(AW), .SW(SW)) u_scale (
        .index_in (index_in),
        .code     (scale_code),
        .enable   (sel.use_scale),
        .scaled   (idx_s)
    );

    assign t_base = sel.use_base  ? base_in : '0;
    assign t_idx  = sel.use_index ? idx_s   : '0;
    assign t_disp = sel.use_disp  ? disp_x  : '0;
    assign ea     = t_base + t_idx + t_disp;

    always_comb begin
        if (mode == 3'd6 || mode == 3'd7) begin
            assert (ea == '0); // R7
        end
    end
endmodule

// File: rtl/eag_real.sv
module eag_real #(
    parameter int AW = 32,
    parameter int GW = 16,
    parameter int OW = 16
) (
    input  logic [GW-1:0] seg_in,
    input  logic [OW-1:0] off_in,
    output logic [AW-1:0] phys
);
    localparam int PW  = GW + 4;
    localparam int PAD = AW - PW;

    logic [PW-1:0] seg_sh;
    logic [PW-1:0] off_x;
    logic [PW-1:0] sum;

    assign seg_sh = {seg_in, 4'h0};
    assign off_x  = {{(PW-OW){1'b0}}, off_in};
    assign sum    = seg_sh + off_x;
    assign phys   = {{PAD{1'b0}}, sum};

    always_comb begin
        assert (phys[AW-1:PW] == '0); // R8
    end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg
    import eag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q,
    output logic          q_valid
);
    out_state_e state_q, state_d;
    logic [AW-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = load ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = load ? ST_LOADED : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= d;
    end

    always_comb begin
        q       = hold_q;
        q_valid = (state_q == ST_LOADED);
    end

    AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q_valid); // R9
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q) && !q_valid); // R10
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 16,
    parameter int SW         = 2,
    parameter int GW         = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [31:0]   base_val,
    input  logic [31:0]   index_val,
    input  logic [1:0]    scale_code,
    input  logic [15:0]   disp,
    input  logic [15:0]   seg_val,
    input  logic          real_en,
    output logic [31:0]   addr,
    output logic          addr_valid
);
    localparam int OW = 16;

    logic [AW-1:0] ea;
    logic [AW-1:0] phys;
    logic [AW-1:0] next_addr;

    eag_sum #(.AW(AW), .DW(DW), .SW(SW)) u_sum (
        .mode       (mode),
        .base_in    (base_val),
        .index_in   (index_val),
        .scale_code (scale_code),
        .disp_in    (disp),
        .ea         (ea)
    );

    eag_real #(.AW(AW), .GW(GW), .OW(OW)) u_real (
        .seg_in (seg_val),
        .off_in (ea[OW-1:0]),
        .phys   (phys)
    );

    assign next_addr = real_en ? phys : ea;

    generate
        if (REGISTERED) begin : g_reg
            eag_outreg #(.AW(AW)) u_out (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (in_valid),
                .d       (next_addr),
                .q       (addr),
                .q_valid (addr_valid)
            );
            AST_REAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && real_en) |=> addr[AW-1:GW+4] == '0); // R8
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> addr == '0 && !addr_valid); // R11
        end else begin : g_comb
            assign addr       = next_addr;
            assign addr_valid = in_valid;
        end
    endgenerate
endmodule

// File: tb/tb_eag_unit.sv
module tb_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [15:0] disp = '0;
    logic [15:0] seg_val = '0;
    logic        real_en = 1'b0;
    logic [31:0] addr;
    logic        addr_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eag_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .base_val(base_val), .index_val(index_val), .scale_code(scale_code),
        .disp(disp), .seg_val(seg_val), .real_en(real_en),
        .addr(addr), .addr_valid(addr_valid)
    );

    function automatic logic [31:0] model(input logic [2:0] m, input logic [31:0] b,
        input logic [31:0] i, input logic [1:0] s, input logic [15:0] d,
        input logic [15:0] g, input logic r);
        logic [31:0] sx;
        logic [31:0] e;
        logic [31:0] p;
        sx = {{16{d[15]}}, d};
        case (m)
            3'd0: e = sx;
            3'd1: e = b;
            3'd2: e = b + i;
            3'd3: e = b + sx;
            3'd4: e = b + i + sx;
            3'd5: e = b + i * (32'd1 << s) + sx;
            default: e = 32'd0;
        endcase
        p = ({12'd0, g, 4'd0} + {16'd0, e[15:0]}) & 32'h000F_FFFF;
        return r ? p : e;
    endfunction

    function automatic string tag(input logic [2:0] m, input logic r);
        if (r) return "R8";
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [31:0] b, input logic [31:0] i,
        input logic [1:0] s, input logic [15:0] d, input logic [15:0] g, input logic r);
        @(negedge clk);
        mode = m; base_val = b; index_val = i; scale_code = s;
        disp = d; seg_val = g; real_en = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag(m, r), addr, model(m, b, i, s, d, g, r));
        check("R9", {31'd0, addr_valid}, 32'd1);
    endtask

    initial begin
        logic [31:0] bases [4];
        logic [31:0] idxs [4];
        logic [15:0] disps [4];
        logic [15:0] segs [4];
        logic [31:0] held;
        bases = '{32'h0000_0300, 32'hFFFF_FFF0, 32'h1234_5678, 32'h8000_0001};
        idxs  = '{32'h0000_0200, 32'h4000_0001, 32'hFFFF_FFFF, 32'h0000_0F0F};
        disps = '{16'h0400, 16'hFFFC, 16'h8000, 16'h7FFF};
        segs  = '{16'h1000, 16'hFFFF, 16'h0000, 16'hABCD};

        repeat (3) @(negedge clk);
        check("R11", addr, 32'd0);
        check("R11", {31'd0, addr_valid}, 32'd0);
        rst_n = 1'b1;

        apply(3'd3, 32'h300, 32'h0, 2'd0, 16'h0400, 16'h0, 1'b0);
        check("R4", addr, 32'h700);
        apply(3'd4, 32'h300, 32'h200, 2'd0, 16'h0400, 16'h0, 1'b0);
        check("R5", addr, 32'h900);
        apply(3'd5, 32'h200, 32'h300, 2'd1, 16'h0000, 16'h0, 1'b0);
        check("R6", addr, 32'h800);

        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
                for (int r = 0; r < 2; r++)
                    for (int k = 0; k < 4; k++)
                        apply(3'(m), bases[k], idxs[(k + s) % 4], 2'(s), disps[(k + m) % 4],
                              segs[(k + r) % 4], r[0]);

        held = addr;
        @(negedge clk);
        mode = 3'd2; base_val = 32'hDEAD_BEEF; index_val = 32'h1; real_en = 1'b0;
        @(negedge clk);
        check("R10", addr, held);
        check("R10", {31'd0, addr_valid}, 32'd0);
        @(negedge clk);
        check("R10", addr, held);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule